// File: doc/BRIEF.md
# Mode-Switching Jump Target Unit

This block resolves the destination of an unconditional (or already-taken) jump in a processor that can address memory in two ways. In the narrow mode, software sees a 16-bit program counter and a fixed 8-bit page register supplies the top byte of every fetch address. In the wide mode, the full 24-bit program counter is used directly. The unit keeps the persistent mode bit and the program counter. On each jump strobe it computes their next values and the 24-bit fetch address.

A jump takes its target either from an immediate operand (2 or 3 bytes) or from a register pair (16 or 24 bits). The decoder can attach a width override that forces the data/mode width and the immediate length. A jump is the only way this unit changes the persistent mode, so an override can move execution between modes. Combinations that make no sense for an immediate jump are rejected. A rejected jump raises a one-cycle flag and leaves the state as it was.

Top module: `jump_target_unit`

## Requirements
- R1: While rst_ni is low, pc_o, addr_o and the mode bit mode_o are all zero and illegal_o is 0.
- R2: The override is described by three bits. sfx_vld_i=1 marks it present, sfx_long_i=1 selects wide data/mode and sfx_ilong_i=1 selects the 3-byte immediate. With sfx_vld_i=0, both width bits take the current value of mode_o. An override that equals the current mode therefore behaves exactly like no override.
- R3: An immediate jump (src_reg_i=0) whose effective widths are both narrow does three things. It writes imm_i[15:0] to pc_o[15:0], keeps pc_o[23:16], and leaves mode_o at 0.
- R4: An immediate jump whose effective widths are both wide writes imm_i[23:0] to pc_o and sets mode_o to 1.
- R5: An immediate jump whose effective data width and immediate length differ is illegal. illegal_o is 1 for the cycle after the strobe, and pc_o, mode_o and addr_o do not change.
- R6: A register jump (src_reg_i=1) with wide effective data width writes reg_i[23:0] to pc_o and sets mode_o to 1.
- R7: A register jump with narrow effective data width writes reg_i[15:0] to pc_o[15:0], keeps pc_o[23:16] and clears mode_o. For register jumps, sfx_ilong_i has no effect and illegal_o stays 0.
- R8: addr_o equals pc_o when mode_o is 1. When mode_o is 0, addr_o is {page_i sampled at the jump, pc_o[15:0]}.
- R9: Outputs change only at a rising clock edge with jump_en_i high. Without a strobe, pc_o, mode_o and addr_o hold even if page_i or the operands change, and illegal_o is 0.
- R10: The outputs reflect a jump from the first rising edge at which jump_en_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jump_en_i | input | 1 | Taken-jump strobe |
| src_reg_i | input | 1 | 1 = register-pair target, 0 = immediate target |
| sfx_vld_i | input | 1 | Width override present |
| sfx_long_i | input | 1 | Override data/mode width, 1 = wide |
| sfx_ilong_i | input | 1 | Override immediate length, 1 = 3 bytes |
| imm_i | input | 24 | Immediate operand bytes |
| reg_i | input | 24 | Register pair value |
| page_i | input | 8 | Page register for narrow-mode addresses |
| pc_o | output | 24 | Program counter |
| mode_o | output | 1 | Persistent mode, 1 = wide |
| addr_o | output | 24 | Fetch address of the new PC |
| illegal_o | output | 1 | Rejected-override pulse |

## Verification
The bench drives both override combinations that are rejected, in each mode. A design that decoded them loosely would move the PC or flip the mode instead of flagging. It also runs narrow jumps out of wide mode. Here a design that cleared the top PC byte, or left addr_o pointing at the old wide address, shows a wrong value. Register jumps are issued with a deliberately mismatched immediate-length bit, so a unit that applied the immediate legality rule to them raises a false illegal pulse. The bench also changes the page register between jumps, which exposes a design that builds addr_o combinationally instead of sampling the page at the strobe.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  typedef enum logic {JT_IMM = 1'b0, JT_REG = 1'b1} jt_src_e;

  typedef struct packed {
    logic wide;     // effective data/mode width
    logic illegal;  // rejected override
  } jt_dec_t;
endpackage

// File: rtl/jtu_decode.sv
module jtu_decode
  import jtu_pkg::*;
(
  input  logic    cur_mode_i,
  input  jt_src_e src_i,
  input  logic    sfx_vld_i,
  input  logic    sfx_long_i,
  input  logic    sfx_ilong_i,
  output jt_dec_t dec_o
);
  logic eff_long, eff_ilong;

  // absent override inherits the current mode for both widths
  assign eff_long  = sfx_vld_i ? sfx_long_i  : cur_mode_i;
  assign eff_ilong = sfx_vld_i ? sfx_ilong_i : cur_mode_i;

  always_comb begin
    dec_o.wide    = eff_long;
    dec_o.illegal = (src_i == JT_IMM) && (eff_long != eff_ilong);
  end
endmodule

// File: rtl/jtu_compose.sv
module jtu_compose #(
  parameter int PC_W   = 24,
  parameter int PAGE_W = 8,
  localparam int LOW_W = PC_W - PAGE_W
) (
  input  logic [PC_W-1:0]   pc_cur_i,
  input  logic [PC_W-1:0]   operand_i,
  input  logic              wide_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_new_o,
  output logic [PC_W-1:0]   addr_new_o
);
  always_comb begin
    if (wide_i) begin
      pc_new_o   = operand_i;
      addr_new_o = operand_i;
    end else begin
      // narrow write keeps the upper PC bits
      pc_new_o   = {pc_cur_i[PC_W-1:LOW_W], operand_i[LOW_W-1:0]};
      addr_new_o = {page_i, operand_i[LOW_W-1:0]};
    end
  end
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int PAGE_W = 8,
  localparam int LOW_W = PC_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              jump_en_i,
  input  logic              src_reg_i,
  input  logic              sfx_vld_i,
  input  logic              sfx_long_i,
  input  logic              sfx_ilong_i,
  input  logic [PC_W-1:0]   imm_i,
  input  logic [PC_W-1:0]   reg_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              mode_o,
  output logic [PC_W-1:0]   addr_o,
  output logic              illegal_o
);
  jt_src_e         src;
  jt_dec_t         dec;
  logic [PC_W-1:0] operand, pc_new, addr_new;

  assign src     = src_reg_i ? JT_REG : JT_IMM;
  assign operand = (src == JT_REG) ? reg_i : imm_i;

  jtu_decode u_decode (
    .cur_mode_i (mode_o),
    .src_i      (src),
    .sfx_vld_i  (sfx_vld_i),
    .sfx_long_i (sfx_long_i),
    .sfx_ilong_i(sfx_ilong_i),
    .dec_o      (dec)
  );

  jtu_compose #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_compose (
    .pc_cur_i  (pc_o),
    .operand_i (operand),
    .wide_i    (dec.wide),
    .page_i    (page_i),
    .pc_new_o  (pc_new),
    .addr_new_o(addr_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o      <= '0;
      mode_o    <= 1'b0;
      addr_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= jump_en_i && dec.illegal;
      if (jump_en_i && !dec.illegal) begin
        pc_o   <= pc_new;
        mode_o <= dec.wide;
        addr_o <= addr_new;
      end
    end
  end

  // R5
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(pc_o) && $stable(mode_o) && $stable(addr_o)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(jump_en_i) |-> ($stable(pc_o) && $stable(mode_o) && $stable(addr_o) && !illegal_o));

  // R8
  addr_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> (addr_o == pc_o));

  // R8
  addr_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> (addr_o[LOW_W-1:0] == pc_o[LOW_W-1:0]));

  // R7
  reg_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_en_i && src_reg_i) |=> !illegal_o);

  // R6
  reg_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_en_i && src_reg_i && sfx_vld_i) |=> (mode_o == $past(sfx_long_i)));
endmodule

// File: tb/tb_jump_target_unit.sv
module tb_jump_target_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        jump_en, src_reg, sfx_vld, sfx_long, sfx_ilong;
  logic [23:0] imm, regv;
  logic [7:0]  page;
  logic [23:0] pc, addr;
  logic        mode, illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_target_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .jump_en_i(jump_en), .src_reg_i(src_reg),
    .sfx_vld_i(sfx_vld), .sfx_long_i(sfx_long), .sfx_ilong_i(sfx_ilong),
    .imm_i(imm), .reg_i(regv), .page_i(page),
    .pc_o(pc), .mode_o(mode), .addr_o(addr), .illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_state(input string tag, input logic [23:0] e_pc, input logic e_mode,
                              input logic [23:0] e_addr, input logic e_ill);
    chk({tag, " pc"}, {8'h0, pc}, {8'h0, e_pc});
    chk({tag, " mode"}, {31'h0, mode}, {31'h0, e_mode});
    chk({tag, " addr"}, {8'h0, addr}, {8'h0, e_addr});
    chk({tag, " illegal"}, {31'h0, illegal}, {31'h0, e_ill});
  endtask

  // one strobe; outputs sampled at the negedge after the capturing edge (R10)
  task automatic jump(input logic s_reg, input logic v, input logic l, input logic il,
                      input logic [23:0] op, input logic [7:0] pg);
    @(negedge clk);
    src_reg = s_reg; sfx_vld = v; sfx_long = l; sfx_ilong = il;
    imm = s_reg ? 24'h5A5A5A : op;
    regv = s_reg ? op : 24'hA5A5A5;
    page = pg; jump_en = 1'b1;
    @(negedge clk);
    jump_en = 1'b0;
  endtask

  task automatic t_reset;
    expect_state("R1 reset", 24'h0, 1'b0, 24'h0, 1'b0);
  endtask

  task automatic t_imm_narrow;
    jump(1'b0, 1'b0, 1'b0, 1'b0, 24'hAB1234, 8'h5C);
    expect_state("R3 imm narrow no override", 24'h001234, 1'b0, 24'h5C1234, 1'b0);
    jump(1'b0, 1'b1, 1'b0, 1'b0, 24'h992222, 8'h5C);
    expect_state("R2 matching narrow override", 24'h002222, 1'b0, 24'h5C2222, 1'b0);
  endtask

  task automatic t_imm_wide;
    jump(1'b0, 1'b1, 1'b1, 1'b1, 24'h3A4B5C, 8'h5C);
    expect_state("R4 wide override from narrow", 24'h3A4B5C, 1'b1, 24'h3A4B5C, 1'b0);
    jump(1'b0, 1'b0, 1'b0, 1'b0, 24'h112233, 8'h77);
    expect_state("R4 wide no override", 24'h112233, 1'b1, 24'h112233, 1'b0);
  endtask

  task automatic t_illegal_wide;
    jump(1'b0, 1'b1, 1'b0, 1'b1, 24'h777777, 8'h01);
    expect_state("R5 narrow/long-imm in wide", 24'h112233, 1'b1, 24'h112233, 1'b1);
    @(negedge clk);
    chk("R9 illegal pulse ends", {31'h0, illegal}, 32'h0);
    jump(1'b0, 1'b1, 1'b1, 1'b0, 24'h888888, 8'h01);
    expect_state("R5 wide/short-imm in wide", 24'h112233, 1'b1, 24'h112233, 1'b1);
  endtask

  task automatic t_match_wide_and_drop;
    jump(1'b0, 1'b1, 1'b1, 1'b1, 24'h445566, 8'h01);
    expect_state("R2 matching wide override", 24'h445566, 1'b1, 24'h445566, 1'b0);
    jump(1'b0, 1'b1, 1'b0, 1'b0, 24'hFFABCD, 8'h12);
    expect_state("R3 narrow override from wide", 24'h44ABCD, 1'b0, 24'h12ABCD, 1'b0);
  endtask

  task automatic t_illegal_narrow;
    jump(1'b0, 1'b1, 1'b0, 1'b1, 24'h010203, 8'h33);
    expect_state("R5 narrow/long-imm in narrow", 24'h44ABCD, 1'b0, 24'h12ABCD, 1'b1);
    jump(1'b0, 1'b1, 1'b1, 1'b0, 24'h040506, 8'h33);
    expect_state("R5 wide/short-imm in narrow", 24'h44ABCD, 1'b0, 24'h12ABCD, 1'b1);
  endtask

  task automatic t_register;
    jump(1'b1, 1'b1, 1'b1, 1'b0, 24'h0F1E2D, 8'h33);
    expect_state("R6 reg wide override, ilong ignored", 24'h0F1E2D, 1'b1, 24'h0F1E2D, 1'b0);
    jump(1'b1, 1'b0, 1'b0, 1'b0, 24'hA0B0C0, 8'h33);
    expect_state("R6 reg wide no override", 24'hA0B0C0, 1'b1, 24'hA0B0C0, 1'b0);
    jump(1'b1, 1'b1, 1'b0, 1'b1, 24'h667788, 8'h21);
    expect_state("R7 reg narrow override, ilong ignored", 24'hA07788, 1'b0, 24'h217788, 1'b0);
    jump(1'b1, 1'b0, 1'b1, 1'b1, 24'h998877, 8'h42);
    expect_state("R7 reg narrow no override", 24'hA08877, 1'b0, 24'h428877, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    src_reg = 1'b0; sfx_vld = 1'b1; sfx_long = 1'b1; sfx_ilong = 1'b0;
    imm = 24'hDEADBE; regv = 24'hBEEF00; page = 8'hE7;
    repeat (3) @(negedge clk);
    expect_state("R9 idle hold, R8 page sampled at jump", 24'hA08877, 1'b0, 24'h428877, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; jump_en = 1'b0; src_reg = 1'b0; sfx_vld = 1'b0;
    sfx_long = 1'b0; sfx_ilong = 1'b0; imm = '0; regv = '0; page = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm_narrow();
    t_imm_wide();
    t_illegal_wide();
    t_match_wide_and_drop();
    t_illegal_narrow();
    t_register();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule